// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames on a single line and hands each byte to a bus-side data register. A frame is a low start bit, DATA_W data bits sent least significant bit first, an optional parity bit, and one stop bit. The line is sampled with a 16x oversampling tick after a two-flop synchronizer. At the end of every frame, a small decision stage works out three things: which error flags to raise, whether the byte moves from the shift register into the data register, and whether the data-full flag is set.

The status word holds four flags: data-full, overrun, framing error and parity error. Reading the data register (a one-cycle `rd_en_i` pulse) clears data-full. The three error flags stay set until the bus writes a zero into their bit position. When one frame has several errors, every matching flag rises in the same clock. Only an overrun stops the byte from being transferred. A frame with a framing or parity error still delivers its byte but leaves data-full at its previous value.

The receive state machine has five states:
- RX_IDLE moves to RX_START on a tick that sees the line low.
- RX_START returns to RX_IDLE if the line is high at the half-bit sample; otherwise it moves to RX_DATA.
- RX_DATA moves to RX_PARITY after the last data bit when parity is enabled, or to RX_STOP when it is not.
- RX_PARITY moves to RX_STOP after one bit.
- RX_STOP moves to RX_IDLE after sampling the stop bit and raising the one-cycle frame-done pulse.

Top module: `uart_rx_errflags`

## Requirements
- R1: After reset, `stat_o` is 4'b0000 and `rx_data_o` is 0. The `stat_o` bits are: [3] data-full, [2] overrun, [1] framing error, [0] parity error.
- R2: A low level that is no longer low at the half-bit sample (8 ticks after the falling tick) is dropped without changing `stat_o` or `rx_data_o`.
- R3: A frame with no errors that ends while data-full is clear loads the byte (first bit received is bit 0) into `rx_data_o` and sets data-full.
- R4: A frame that ends while data-full is set raises overrun, leaves `rx_data_o` unchanged and keeps data-full set.
- R5: A stop bit sampled low raises the framing-error flag; the byte is still loaded, and data-full keeps its previous value.
- R6: With `par_en_i`=1, the parity bit is expected to make the count of ones over data and parity even when `par_odd_i`=0, and odd when `par_odd_i`=1. A mismatch raises the parity-error flag, the byte is still loaded, and data-full keeps its previous value. With `par_en_i`=0 no parity bit is received and the flag never rises.
- R7: When a frame has several errors, all their flags rise in the same clock, and only an overrun blocks the load into `rx_data_o`.
- R8: A pulse on `rd_en_i` clears data-full and leaves the three error flags unchanged.
- R9: An error flag clears only when `stat_wr_i` is high and its bit of `stat_wdata_i` is 0 (bit [2] overrun, [1] framing, [0] parity). Writing 1 leaves the flag as it was.
- R10: The flags and data register update in one clock, driven only by the frame-done event, a data read or a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | Oversampling tick, 16 per bit time |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| rd_en_i | input | 1 | Data register read strobe, clears data-full |
| rx_data_o | output | DATA_W | Receive data register |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 3 | Write data; 0 in a bit clears that error flag |
| stat_o | output | 4 | {data-full, overrun, framing, parity} |

## Verification
The hardest case is a single frame that carries an overrun, a framing error and a parity error together. Reaching it takes several steps:
- A clean frame is sent first and left unread, so that data-full is set.
- A second frame is then sent with a deliberately wrong parity bit and a low stop bit.

The bench sweeps all eight error combinations in three parity configurations, using several byte values. For each case it computes the expected flags, data register and data-full value arithmetically from the requirements.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

    // bit positions inside the error-flag vector and the status word
    localparam int FLG_PAR  = 0;
    localparam int FLG_FRM  = 1;
    localparam int FLG_OVR  = 2;
    localparam int FLG_FULL = 3;
    localparam int NUM_ERR  = 3;

endpackage

// File: rtl/rx_sampler.sv
`timescale 1ns/1ps
module rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              tick_i,
    input  logic              par_en_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              par_bit_o,
    output logic              stop_bit_o
);

    localparam int CNT_W = $clog2(OS_RATE);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OS_RATE - 1);
    localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(DATA_W - 1);

    logic                 rx_s;
    rx_state_t            st_q, st_n;
    logic [CNT_W-1:0]     cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [DATA_W-1:0]    shift_q;
    logic                 par_q;
    logic                 stop_q;
    logic                 done_q;
    logic                 mid_bit;
    logic                 half_bit;

    // line synchronizer: depth picked by parameter
    generate
        if (SYNC_STAGES > 1) begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
            end
            assign rx_s = sync_q[SYNC_STAGES-1];
        end else begin : g_sync1
            logic sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= 1'b1;
                else        sync_q <= rx_i;
            end
            assign rx_s = sync_q;
        end
    endgenerate

    assign mid_bit  = tick_i && (cnt_q == FULL_M1);
    assign half_bit = tick_i && (cnt_q == HALF_M1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_n;
    end

    // next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            RX_IDLE:   if (tick_i && !rx_s) st_n = RX_START;
            RX_START:  if (half_bit)        st_n = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:   if (mid_bit && idx_q == LAST_IX)
                           st_n = par_en_i ? RX_PARITY : RX_STOP;
            RX_PARITY: if (mid_bit)         st_n = RX_STOP;
            RX_STOP:   if (mid_bit)         st_n = RX_IDLE;
            default:                        st_n = RX_IDLE;
        endcase
    end

    // per-state datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
            stop_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                end
                RX_START: begin
                    if (tick_i) cnt_q <= half_bit ? '0 : cnt_q + 1'b1;
                end
                RX_DATA: begin
                    if (tick_i) cnt_q <= mid_bit ? '0 : cnt_q + 1'b1;
                    if (mid_bit) begin
                        shift_q <= {rx_s, shift_q[DATA_W-1:1]};
                        idx_q   <= idx_q + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (tick_i)  cnt_q <= mid_bit ? '0 : cnt_q + 1'b1;
                    if (mid_bit) par_q <= rx_s;
                end
                RX_STOP: begin
                    if (tick_i) cnt_q <= mid_bit ? '0 : cnt_q + 1'b1;
                    if (mid_bit) begin
                        stop_q <= rx_s;
                        done_q <= 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign done_o     = done_q;
    assign data_o     = shift_q;
    assign par_bit_o  = par_q;
    assign stop_bit_o = stop_q;

endmodule

// File: rtl/rx_frame_check.sv
`timescale 1ns/1ps
module rx_frame_check
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               done_i,
    input  logic [DATA_W-1:0]  data_i,
    input  logic               par_bit_i,
    input  logic               stop_bit_i,
    input  logic               par_en_i,
    input  logic               par_odd_i,
    input  logic               full_i,
    output logic [NUM_ERR-1:0] err_hit_o,
    output logic               xfer_o,
    output logic               set_full_o
);

    logic ovr_e, frm_e, par_e;

    always_comb begin
        ovr_e = done_i && full_i;
        frm_e = done_i && !stop_bit_i;
        par_e = done_i && par_en_i && ((^data_i ^ par_bit_i) != par_odd_i);
        err_hit_o          = '0;
        err_hit_o[FLG_OVR] = ovr_e;
        err_hit_o[FLG_FRM] = frm_e;
        err_hit_o[FLG_PAR] = par_e;
        xfer_o     = done_i && !full_i;
        set_full_o = done_i && !full_i && !frm_e && !par_e;
    end

endmodule

// File: rtl/rx_status_regs.sv
`timescale 1ns/1ps
module rx_status_regs
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DATA_W-1:0]  data_i,
    input  logic               xfer_i,
    input  logic               set_full_i,
    input  logic [NUM_ERR-1:0] err_hit_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic [NUM_ERR-1:0] wdata_i,
    output logic [DATA_W-1:0]  data_o,
    output logic               full_o,
    output logic [NUM_ERR-1:0] err_o
);

    logic [DATA_W-1:0]  data_q;
    logic               full_q;
    logic [NUM_ERR-1:0] err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (xfer_i) data_q <= data_i;
            if (set_full_i)   full_q <= 1'b1;
            else if (rd_en_i) full_q <= 1'b0;
        end
    end

    // one sticky flag per error kind; a new hit wins over a clear
    generate
        for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      err_q[g] <= 1'b0;
                else if (err_hit_i[g])           err_q[g] <= 1'b1;
                else if (wr_en_i && !wdata_i[g]) err_q[g] <= 1'b0;
            end
        end
    endgenerate

    assign data_o = data_q;
    assign full_o = full_q;
    assign err_o  = err_q;

endmodule

// File: rtl/uart_rx_errflags.sv
`timescale 1ns/1ps
module uart_rx_errflags
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              os_tick_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rx_data_o,
    input  logic              stat_wr_i,
    input  logic [2:0]        stat_wdata_i,
    output logic [3:0]        stat_o
);

    logic               frame_done;
    logic [DATA_W-1:0]  shift_data;
    logic               par_bit;
    logic               stop_bit;
    logic               full;
    logic [NUM_ERR-1:0] err_hit;
    logic [NUM_ERR-1:0] err_flags;
    logic               xfer;
    logic               set_full;

    rx_sampler #(
        .DATA_W      (DATA_W),
        .OS_RATE     (OS_RATE),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_samp (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_i       (rx_i),
        .tick_i     (os_tick_i),
        .par_en_i   (par_en_i),
        .done_o     (frame_done),
        .data_o     (shift_data),
        .par_bit_o  (par_bit),
        .stop_bit_o (stop_bit)
    );

    rx_frame_check #(
        .DATA_W (DATA_W)
    ) u_chk_frame (
        .done_i     (frame_done),
        .data_i     (shift_data),
        .par_bit_i  (par_bit),
        .stop_bit_i (stop_bit),
        .par_en_i   (par_en_i),
        .par_odd_i  (par_odd_i),
        .full_i     (full),
        .err_hit_o  (err_hit),
        .xfer_o     (xfer),
        .set_full_o (set_full)
    );

    rx_status_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_i     (shift_data),
        .xfer_i     (xfer),
        .set_full_i (set_full),
        .err_hit_i  (err_hit),
        .rd_en_i    (rd_en_i),
        .wr_en_i    (stat_wr_i),
        .wdata_i    (stat_wdata_i),
        .data_o     (rx_data_o),
        .full_o     (full),
        .err_o      (err_flags)
    );

    assign stat_o = {full, err_flags};

endmodule

// File: rtl/uart_rx_errflags_chk.sv
`timescale 1ns/1ps
module uart_rx_errflags_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              par_en,
    input logic              rd_en,
    input logic              wr_en,
    input logic [2:0]        wdata,
    input logic [DATA_W-1:0] data,
    input logic [3:0]        stat
);

    // R3
    full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[3]) |-> $past(done));

    // R4
    ovr_hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stat[3]) |=> $stable(data));

    // R4
    ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[2]) |-> $past(done && stat[3]));

    // R6
    par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[0]) |-> $past(par_en));

    // R7
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stat[1]) || $rose(stat[0])) |-> $past(done));

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !done) |=> !stat[3]);

    // R9
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stat[2]) || $fell(stat[1]) || $fell(stat[0])) |-> $past(wr_en));

    // R9
    write_one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata == 3'b111) |=> (stat[2:0] >= $past(stat[2:0])));

    // R10
    data_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data) |-> $past(done && !stat[3]));

endmodule

bind uart_rx_errflags uart_rx_errflags_chk #(.DATA_W(DATA_W)) u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (frame_done),
    .par_en (par_en_i),
    .rd_en  (rd_en_i),
    .wr_en  (stat_wr_i),
    .wdata  (stat_wdata_i),
    .data   (rx_data_o),
    .stat   (stat_o)
);

// File: tb/sim_uart_rx_errflags.sv
`timescale 1ns/1ps
module sim_uart_rx_errflags;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wdata = 3'b000;
    logic [7:0] rdata;
    logic [3:0] stat;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    logic [1:0] tcnt = 2'd0;

    always #10 clk = ~clk;

    // tick on one clock out of three
    always_ff @(posedge clk) tcnt <= (tcnt == 2'd2) ? 2'd0 : tcnt + 2'd1;
    assign tick = (tcnt == 2'd0);

    uart_rx_errflags u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_i         (rx),
        .os_tick_i    (tick),
        .par_en_i     (par_en),
        .par_odd_i    (par_odd),
        .rd_en_i      (rd_en),
        .rx_data_o    (rdata),
        .stat_wr_i    (wr_en),
        .stat_wdata_i (wdata),
        .stat_o       (stat)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic tick_wait();
        do @(negedge clk); while (!tick);
        @(posedge clk);
        #1;
    endtask

    task automatic hold_bit(input logic v);
        rx = v;
        repeat (16) tick_wait();
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par, input logic stop_v);
        logic p;
        p = par_odd ? ~^b : ^b;
        if (bad_par) p = ~p;
        tick_wait();
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        if (par_en) hold_bit(p);
        hold_bit(stop_v);
        rx = 1'b1;
        repeat (24) tick_wait();
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic write_stat(input logic [2:0] v);
        @(negedge clk) begin wr_en = 1'b1; wdata = v; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    function automatic string tag_of(input bit o, input bit f, input bit pe);
        if (o && (f || pe)) return "R7";
        if (o)              return "R4";
        if (f && pe)        return "R7";
        if (f)              return "R5";
        if (pe)             return "R6";
        return "R3";
    endfunction

    initial begin
        #(20 * 190000);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] b, prev;
        logic [3:0] exp_stat;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "status after reset", int'(stat), 0);
        chk("R1", "data after reset", int'(rdata), 0);

        // R2 short low pulse is dropped
        tick_wait();
        rx = 1'b0;
        repeat (4) tick_wait();
        rx = 1'b1;
        repeat (40) tick_wait();
        chk("R2", "status after glitch", int'(stat), 0);
        chk("R2", "data after glitch", int'(rdata), 0);

        // main sweep: parity configuration x error combination x byte
        for (int cfg = 0; cfg < 3; cfg++) begin
            par_en  = (cfg != 0);
            par_odd = (cfg == 2);
            for (int combo = 0; combo < 8; combo++) begin
                for (int k = 0; k < 3; k++) begin
                    bit o, f, pe;
                    o  = combo[2];
                    f  = combo[1];
                    pe = combo[0];
                    b    = 8'(8'h5A + combo * 29 + k * 83 + cfg * 11);
                    prev = ~b ^ 8'(k + 1);
                    write_stat(3'b000);
                    pulse_rd();
                    if (o) send_frame(prev, 1'b0, 1'b1);
                    send_frame(b, pe, !f);
                    exp_stat[3] = o ? 1'b1 : !(f || (pe && par_en));
                    exp_stat[2] = o;
                    exp_stat[1] = f;
                    exp_stat[0] = pe && par_en;
                    chk(tag_of(o, f, pe && par_en), "status", int'(stat), int'(exp_stat));
                    chk(tag_of(o, f, pe && par_en), "data", int'(rdata), o ? int'(prev) : int'(b));
                end
            end
        end

        // R8 read clears full only; R9 write-one keeps, write-zero clears
        par_en = 1'b1;
        par_odd = 1'b0;
        write_stat(3'b000);
        pulse_rd();
        send_frame(8'hC3, 1'b1, 1'b0);
        send_frame(8'h81, 1'b0, 1'b1);
        chk("R3", "status clean frame after errors", int'(stat), 4'b1011);
        chk("R3", "data clean frame", int'(rdata), 8'h81);
        pulse_rd();
        chk("R8", "status after read", int'(stat), 4'b0011);
        chk("R8", "data kept after read", int'(rdata), 8'h81);
        write_stat(3'b111);
        chk("R9", "status after write ones", int'(stat), 4'b0011);
        write_stat(3'b101);
        chk("R9", "status after clearing framing", int'(stat), 4'b0001);
        write_stat(3'b110);
        chk("R9", "status after clearing parity", int'(stat), 4'b0000);

        // R6 disabled parity: a frame with no parity bit is accepted
        par_en = 1'b0;
        send_frame(8'h00, 1'b0, 1'b1);
        chk("R6", "status parity off", int'(stat), 4'b1000);
        chk("R10", "data parity off", int'(rdata), 8'h00);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule